// File: doc/BRIEF.md
# Stack-Addressed Floating Register File

This block holds eight 80-bit values that software addresses relative to a movable top pointer rather than by fixed position. Stack-relative name ST(i) resolves to physical entry (top + i) mod 8. A push places a new value on the stack. A pop discards the top. An exchange swaps the top with any other stack slot.

Two operand views are always visible. ST(0) appears on one read port and ST(i) on the other, where i is the index supplied with the operation. An arithmetic unit outside the block consumes these operands. It hands its result back on a dedicated port, and the result is always written into the current top entry.

Each entry carries a valid tag. Pushing onto an occupied entry raises an overflow flag. Touching an empty entry raises an underflow flag. In both cases the rejected operation leaves the stack untouched. The entries themselves are opaque: no rounding, exceptions or arithmetic happen here.

Top module: `fstk_core`

## Requirements
- R1: After reset the top pointer is 0, every entry is empty, and both flags are low.
- R2: The read port for ST(i) returns physical entry (top + i) mod 8, so slot naming wraps around the eight entries.
- R3: Op code 1 (push) lowers the top pointer by one modulo 8, writes the push data there and marks it valid.
- R4: A push whose target entry is already valid raises the overflow flag for one cycle. The push is rejected, so the top pointer and all entries stay unchanged.
- R5: Op code 2 (pop) on a valid top marks that entry empty and raises the top pointer by one modulo 8.
- R6: A pop of an empty top raises the underflow flag for one cycle and changes nothing.
- R7: Op code 3 (exchange) swaps ST(0) with ST(i) in one cycle. If either slot is empty, the swap is skipped and the underflow flag is raised.
- R8: A result strobe writes the result into the entry that is ST(0) at that cycle and marks it valid.
- R9: While a result strobe is high, the ST(0) read port already shows the result value and reports non-empty in that same cycle.
- R10: When a result and a push, pop or exchange fall in the same cycle, the result is applied first and the stack operation then acts on it. An exchange moves the result to ST(i), a pop discards it, and a push keeps it at ST(1).
- R11: Op codes 4 (one-operand use) and 5 (two-operand use) change no state. They raise the underflow flag when ST(0), or ST(0) or ST(i) respectively, is empty. Op code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Stack operation strobe |
| op_code | input | 3 | 0 none, 1 push, 2 pop, 3 exchange, 4 use one, 5 use two |
| op_idx | input | 3 | Relative index i for exchange, two-operand use and the ST(i) port |
| push_data | input | 80 | Value written by a push |
| res_valid | input | 1 | Result write strobe from the arithmetic unit |
| res_data | input | 80 | Result value, written to ST(0) |
| top_ptr | output | 3 | Current physical top index |
| st0_data | output | 80 | Value of ST(0), with result forwarding |
| st0_empty | output | 1 | ST(0) holds no value |
| sti_data | output | 80 | Value of ST(op_idx) |
| sti_empty | output | 1 | ST(op_idx) holds no value |
| ovf_flag | output | 1 | One-cycle overflow pulse after a rejected push |
| unf_flag | output | 1 | One-cycle underflow pulse after an access to an empty entry |

## Verification
The delicate overlap is a result write-back landing in the same cycle as a push, pop or exchange. Both act on the entry at the current top, so their order decides what survives. The bench drives the result strobe together with each of those three operations. It then compares ST(0), ST(i), the pointer and the flags against a stack model that applies the result first. Read forwarding is judged inside the strobe cycle itself, by sampling ST(0) before the clock edge commits the write.

// File: rtl/fstk_pkg.sv
package fstk_pkg;
    localparam int FS_DEPTH = 8;
    localparam int FS_WIDTH = 80;
    localparam int FS_PTRW  = $clog2(FS_DEPTH);

    typedef enum logic [2:0] {
        FS_NOP  = 3'd0,
        FS_PUSH = 3'd1,
        FS_POP  = 3'd2,
        FS_XCHG = 3'd3,
        FS_USE1 = 3'd4,
        FS_USE2 = 3'd5
    } fs_op_e;
endpackage

// File: rtl/fstk_ctl.sv
module fstk_ctl
    import fstk_pkg::*;
#(
    parameter int DEPTH = FS_DEPTH,
    parameter int PTRW  = FS_PTRW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [PTRW-1:0] op_idx,
    input  logic            res_valid,
    input  logic [DEPTH-1:0] tag_q,
    output logic [PTRW-1:0] top_q,
    output logic [PTRW-1:0] push_ptr,
    output logic [PTRW-1:0] alt_ptr,
    output logic            do_push,
    output logic            do_pop,
    output logic            do_xchg,
    output logic            ovf_q,
    output logic            unf_q
);
    typedef struct packed {
        logic [PTRW-1:0] top;
        logic            ovf;
        logic            unf;
    } ctl_t;

    ctl_t            st_d, st_q;
    logic [DEPTH-1:0] eff_tag;
    fs_op_e          op;

    assign op       = fs_op_e'(op_code);
    assign push_ptr = st_q.top - PTRW'(1);
    assign alt_ptr  = st_q.top + op_idx;

    always_comb begin
        st_d    = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        do_push = 1'b0;
        do_pop  = 1'b0;
        do_xchg = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            eff_tag[k] = tag_q[k] | (res_valid && (st_q.top == PTRW'(k)));
        end
        if (op_valid) begin
            case (op)
                FS_PUSH: begin
                    if (eff_tag[push_ptr]) begin
                        st_d.ovf = 1'b1;
                    end else begin
                        do_push  = 1'b1;
                        st_d.top = push_ptr;
                    end
                end
                FS_POP: begin
                    if (!eff_tag[st_q.top]) begin
                        st_d.unf = 1'b1;
                    end else begin
                        do_pop   = 1'b1;
                        st_d.top = st_q.top + PTRW'(1);
                    end
                end
                FS_XCHG: begin
                    if (!eff_tag[st_q.top] || !eff_tag[alt_ptr]) begin
                        st_d.unf = 1'b1;
                    end else begin
                        do_xchg = 1'b1;
                    end
                end
                FS_USE1: st_d.unf = !eff_tag[st_q.top];
                FS_USE2: st_d.unf = !eff_tag[st_q.top] || !eff_tag[alt_ptr];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign top_q = st_q.top;
    assign ovf_q = st_q.ovf;
    assign unf_q = st_q.unf;
endmodule

// File: rtl/fstk_regs.sv
module fstk_regs
    import fstk_pkg::*;
#(
    parameter int DEPTH = FS_DEPTH,
    parameter int WIDTH = FS_WIDTH,
    parameter int PTRW  = FS_PTRW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PTRW-1:0]             top_q,
    input  logic                        res_valid,
    input  logic [WIDTH-1:0]            res_data,
    input  logic                        do_push,
    input  logic [PTRW-1:0]             push_ptr,
    input  logic [WIDTH-1:0]            push_data,
    input  logic                        do_pop,
    input  logic                        do_xchg,
    input  logic [PTRW-1:0]             alt_ptr,
    output logic [DEPTH-1:0][WIDTH-1:0] data_q,
    output logic [DEPTH-1:0]            tag_q
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] data;
        logic [DEPTH-1:0]            tag;
    } regs_t;

    regs_t            rf_d, rf_q;
    logic [WIDTH-1:0] swap_tmp;

    always_comb begin
        rf_d     = rf_q;
        swap_tmp = '0;
        // result lands first, so later steps see it
        if (res_valid) begin
            rf_d.data[top_q] = res_data;
            rf_d.tag[top_q]  = 1'b1;
        end
        if (do_push) begin
            rf_d.data[push_ptr] = push_data;
            rf_d.tag[push_ptr]  = 1'b1;
        end
        if (do_pop) begin
            rf_d.tag[top_q] = 1'b0;
        end
        if (do_xchg) begin
            swap_tmp            = rf_d.data[top_q];
            rf_d.data[top_q]    = rf_d.data[alt_ptr];
            rf_d.data[alt_ptr]  = swap_tmp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign data_q = rf_q.data;
    assign tag_q  = rf_q.tag;
endmodule

// File: rtl/fstk_rdport.sv
module fstk_rdport
    import fstk_pkg::*;
#(
    parameter int DEPTH = FS_DEPTH,
    parameter int WIDTH = FS_WIDTH,
    parameter int PTRW  = FS_PTRW
) (
    input  logic [PTRW-1:0]             top_q,
    input  logic [PTRW-1:0]             rel_idx,
    input  logic [DEPTH-1:0][WIDTH-1:0] data_q,
    input  logic [DEPTH-1:0]            tag_q,
    input  logic                        res_valid,
    input  logic [WIDTH-1:0]            res_data,
    output logic [WIDTH-1:0]            rd_data,
    output logic                        rd_empty
);
    logic [PTRW-1:0] phys;
    logic            fwd;

    always_comb begin
        phys     = top_q + rel_idx;
        fwd      = res_valid && (phys == top_q);
        rd_data  = fwd ? res_data : data_q[phys];
        rd_empty = !(fwd || tag_q[phys]);
    end
endmodule

// File: rtl/fstk_core.sv
module fstk_core
    import fstk_pkg::*;
#(
    parameter int DEPTH = FS_DEPTH,
    parameter int WIDTH = FS_WIDTH,
    localparam int PTRW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [PTRW-1:0]  op_idx,
    input  logic [WIDTH-1:0] push_data,
    input  logic             res_valid,
    input  logic [WIDTH-1:0] res_data,
    output logic [PTRW-1:0]  top_ptr,
    output logic [WIDTH-1:0] st0_data,
    output logic             st0_empty,
    output logic [WIDTH-1:0] sti_data,
    output logic             sti_empty,
    output logic             ovf_flag,
    output logic             unf_flag
);
    logic [PTRW-1:0]             top_w, push_ptr_w, alt_ptr_w;
    logic                        push_w, pop_w, xchg_w;
    logic [DEPTH-1:0][WIDTH-1:0] data_w;
    logic [DEPTH-1:0]            tag_w;

    fstk_ctl #(.DEPTH(DEPTH), .PTRW(PTRW)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .op_idx   (op_idx),
        .res_valid(res_valid),
        .tag_q    (tag_w),
        .top_q    (top_w),
        .push_ptr (push_ptr_w),
        .alt_ptr  (alt_ptr_w),
        .do_push  (push_w),
        .do_pop   (pop_w),
        .do_xchg  (xchg_w),
        .ovf_q    (ovf_flag),
        .unf_q    (unf_flag)
    );

    fstk_regs #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTRW(PTRW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .top_q    (top_w),
        .res_valid(res_valid),
        .res_data (res_data),
        .do_push  (push_w),
        .push_ptr (push_ptr_w),
        .push_data(push_data),
        .do_pop   (pop_w),
        .do_xchg  (xchg_w),
        .alt_ptr  (alt_ptr_w),
        .data_q   (data_w),
        .tag_q    (tag_w)
    );

    logic [1:0][PTRW-1:0]  port_idx;
    logic [1:0][WIDTH-1:0] port_data;
    logic [1:0]            port_empty;

    assign port_idx[0] = '0;
    assign port_idx[1] = op_idx;

    for (genvar p = 0; p < 2; p++) begin : g_rd
        fstk_rdport #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTRW(PTRW)) u_rd (
            .top_q    (top_w),
            .rel_idx  (port_idx[p]),
            .data_q   (data_w),
            .tag_q    (tag_w),
            .res_valid(res_valid),
            .res_data (res_data),
            .rd_data  (port_data[p]),
            .rd_empty (port_empty[p])
        );
    end

    assign top_ptr   = top_w;
    assign st0_data  = port_data[0];
    assign st0_empty = port_empty[0];
    assign sti_data  = port_data[1];
    assign sti_empty = port_empty[1];
endmodule

// File: rtl/fstk_chk.sv
module fstk_chk #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 80,
    parameter int PTRW  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic             res_valid,
    input logic [WIDTH-1:0] res_data,
    input logic [PTRW-1:0]  top_ptr,
    input logic [WIDTH-1:0] st0_data,
    input logic             st0_empty,
    input logic             ovf_flag,
    input logic             unf_flag,
    input logic [DEPTH-1:0] tag_w
);
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag && unf_flag));

    a_r3_push_lowers_top: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd1 && !tag_w[top_ptr - PTRW'(1)])
        |=> top_ptr == $past(top_ptr) - PTRW'(1));

    a_r4_overflow_keeps_top: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> $stable(top_ptr));

    a_r5_pop_raises_top: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd2 && (tag_w[top_ptr] || res_valid))
        |=> top_ptr == $past(top_ptr) + PTRW'(1));

    a_r6_underflow_keeps_top: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |-> $stable(top_ptr));

    a_r8_result_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !(op_valid && op_code == 3'd2))
        |=> tag_w[$past(top_ptr)]);

    a_r9_result_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (st0_data == res_data && !st0_empty));
endmodule

bind fstk_core fstk_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTRW(PTRW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .res_valid(res_valid),
    .res_data (res_data),
    .top_ptr  (top_ptr),
    .st0_data (st0_data),
    .st0_empty(st0_empty),
    .ovf_flag (ovf_flag),
    .unf_flag (unf_flag),
    .tag_w    (tag_w)
);

// File: tb/sim_fstk_core.sv
`timescale 1ns/1ps
module sim_fstk_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [2:0]  op_idx = '0;
    logic [79:0] push_data = '0;
    logic        res_valid = 1'b0;
    logic [79:0] res_data = '0;
    logic [2:0]  top_ptr;
    logic [79:0] st0_data, sti_data;
    logic        st0_empty, sti_empty, ovf_flag, unf_flag;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fstk_core u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_idx(op_idx), .push_data(push_data), .res_valid(res_valid),
        .res_data(res_data), .top_ptr(top_ptr), .st0_data(st0_data),
        .st0_empty(st0_empty), .sti_data(sti_data), .sti_empty(sti_empty),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    typedef struct {
        string       req;
        logic [2:0]  top;
        logic        ovf;
        logic        unf;
        logic        e0;
        logic [79:0] d0;
        logic        ei;
        logic [79:0] di;
    } exp_t;

    exp_t sb[$];

    // stack model built from the requirements
    logic [79:0] m_data [8];
    logic        m_tag  [8];
    logic [2:0]  m_top;

    task automatic chk(string req, string what, logic [79:0] act, logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [2:0] op, logic [2:0] idx, logic [79:0] pd,
                         logic rv, logic [79:0] rd, string req);
        exp_t it;
        logic ovf = 1'b0;
        logic unf = 1'b0;
        logic [2:0] alt;
        logic [2:0] np;
        logic [79:0] tmp;
        @(negedge clk);
        op_valid = (op != 3'd0); op_code = op; op_idx = idx;
        push_data = pd; res_valid = rv; res_data = rd;
        #1;
        if (rv) begin
            chk("R9", "st0_data fwd", st0_data, rd);
            chk("R9", "st0_empty fwd", {79'd0, st0_empty}, 80'd0);
            m_data[m_top] = rd;
            m_tag[m_top]  = 1'b1;
        end
        alt = m_top + idx;
        np  = m_top - 3'd1;
        case (op)
            3'd1: if (m_tag[np]) ovf = 1'b1;
                  else begin m_data[np] = pd; m_tag[np] = 1'b1; m_top = np; end
            3'd2: if (!m_tag[m_top]) unf = 1'b1;
                  else begin m_tag[m_top] = 1'b0; m_top = m_top + 3'd1; end
            3'd3: if (!m_tag[m_top] || !m_tag[alt]) unf = 1'b1;
                  else begin tmp = m_data[m_top]; m_data[m_top] = m_data[alt]; m_data[alt] = tmp; end
            3'd4: unf = !m_tag[m_top];
            3'd5: unf = !m_tag[m_top] || !m_tag[alt];
            default: ;
        endcase
        it.req = req; it.top = m_top; it.ovf = ovf; it.unf = unf;
        it.e0 = !m_tag[m_top]; it.d0 = m_data[m_top];
        it.ei = !m_tag[3'(m_top + idx)]; it.di = m_data[3'(m_top + idx)];
        sb.push_back(it);
        @(posedge clk);
        #1;
        op_valid = 1'b0; op_code = '0; res_valid = 1'b0;
    endtask

    // monitor: compare once the edge has committed
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            chk(it.req, "top_ptr", {77'd0, top_ptr}, {77'd0, it.top});
            chk(it.req, "ovf_flag", {79'd0, ovf_flag}, {79'd0, it.ovf});
            chk(it.req, "unf_flag", {79'd0, unf_flag}, {79'd0, it.unf});
            chk(it.req, "st0_empty", {79'd0, st0_empty}, {79'd0, it.e0});
            chk(it.req, "sti_empty", {79'd0, sti_empty}, {79'd0, it.ei});
            if (!it.e0) chk(it.req, "st0_data", st0_data, it.d0);
            if (!it.ei) chk(it.req, "sti_data", sti_data, it.di);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired before the test sequence ended");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) begin m_data[k] = '0; m_tag[k] = 1'b0; end
        m_top = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "top_ptr", {77'd0, top_ptr}, 80'd0);
        chk("R1", "ovf_flag", {79'd0, ovf_flag}, 80'd0);
        chk("R1", "unf_flag", {79'd0, unf_flag}, 80'd0);
        chk("R1", "st0_empty", {79'd0, st0_empty}, 80'd1);
        chk("R1", "sti_empty", {79'd0, sti_empty}, 80'd1);

        apply(3'd1, 3'd1, 80'hA0A0, 0, '0, "R3");
        apply(3'd1, 3'd1, 80'hB1B1, 0, '0, "R3");
        apply(3'd1, 3'd2, 80'hC2C2, 0, '0, "R2");
        apply(3'd0, 3'd0, '0, 1, 80'h5E5E, "R8");
        apply(3'd3, 3'd2, '0, 0, '0, "R7");
        apply(3'd3, 3'd4, '0, 0, '0, "R7");
        apply(3'd5, 3'd1, '0, 0, '0, "R11");
        apply(3'd5, 3'd3, '0, 0, '0, "R11");
        apply(3'd4, 3'd0, '0, 0, '0, "R11");
        apply(3'd3, 3'd1, '0, 1, 80'h7777, "R10");
        apply(3'd1, 3'd1, 80'hD4D4, 1, 80'hE5E5, "R10");
        apply(3'd2, 3'd0, '0, 1, 80'hF6F6, "R10");
        for (int k = 0; k < 4; k++) apply(3'd2, 3'd1, '0, 0, '0, "R5");
        apply(3'd2, 3'd0, '0, 0, '0, "R6");
        apply(3'd4, 3'd0, '0, 0, '0, "R11");
        for (int k = 0; k < 8; k++)
            apply(3'd1, 3'd7, 80'h1000 + 80'(k), 0, '0, "R2");
        apply(3'd1, 3'd7, 80'hDEAD, 0, '0, "R4");
        for (int k = 0; k < 8; k++) apply(3'd2, 3'd1, '0, 0, '0, "R5");
        apply(3'd2, 3'd0, '0, 0, '0, "R6");

        repeat (3) @(posedge clk);
        #3;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule